// File: doc/BRIEF.md
# Indexed Configuration Access Bridge

This block lets a processor reach the configuration space of downstream functions through two memory-mapped registers. An index register selects a target: bus, device and function numbers, plus a dword register number. A data register then either carries the payload of a configuration transaction or acts as a plain scratch register, depending on an enable bit in the index register.

When the enable bit is set, a load or store to the data register is turned into a single configuration read or write request on a downstream valid/ready request channel. The processor access stalls until the matching completion arrives on a completion channel. Only one request is ever in flight. A completion marked as an error returns all-ones read data, and for a write it simply ends the access. When the enable bit is clear, the data register is an ordinary local register with zero wait states, and nothing is sent downstream.

The processor bus is a single-beat valid/ready interface. The index register sits at byte offset 0x0 and the data register at byte offset 0x4. Any other offset reads as zero and ignores writes.

Top module: `cfg_index_bridge`

## Requirements
- R1: After reset the index register and the local data register both read 0, and no request or completion handshake signal is asserted.
- R2: The index register stores enable at bit 31, bus number at bits 23:16, device at 15:11, function at 10:8 and dword register number at 7:2. Each byte lane is written only when its byte enable (bit 3 for byte 3 and so on) is set. Bits 30:24 and 1:0 ignore writes and read back as 0.
- R3: With enable clear, a data-register access completes in the cycle it is presented and stores or returns the local register, byte lanes gated by the byte enables. No downstream request is raised.
- R4: With enable set, a data-register store issues one request with write flag 1, bus/device/function/register taken from the index register, and the store's data and byte enables.
- R5: With enable set, a data-register load issues one request with write flag 0 and returns the completion data on the processor read data.
- R6: A configuration access holds processor ready low until the completion handshake, and raises ready in the cycle right after that handshake.
- R7: While a request is valid and not accepted, the request stays valid and all its fields stay stable.
- R8: A completion with the error flag set returns 0xFFFFFFFF to a load and ends a store normally.
- R9: At most one request is outstanding: no new request is raised between a request handshake and its completion, and each configuration access produces exactly one request.
- R10: Configuration accesses leave the local data register unchanged.
- R11: A load from an offset other than 0x0 or 0x4 returns 0 without waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address within the block |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| dn_req_valid | output | 1 | Configuration request valid |
| dn_req_ready | input | 1 | Request accepted |
| dn_req_write | output | 1 | 1 = configuration write |
| dn_req_bus | output | 8 | Target bus number |
| dn_req_dev | output | 5 | Target device number |
| dn_req_fn | output | 3 | Target function number |
| dn_req_reg | output | 6 | Dword register number |
| dn_req_wdata | output | 32 | Write payload |
| dn_req_be | output | 4 | Write byte enables |
| dn_cpl_valid | input | 1 | Completion valid |
| dn_cpl_ready | output | 1 | Bridge is waiting for a completion |
| dn_cpl_err | input | 1 | Completion reports an error |
| dn_cpl_data | input | 32 | Completion read data |

## Verification
The data register is exercised with enable clear, using full and partial byte enables, and with enable set for stores and loads. This separates the local path from the forwarded path, and the monitor flags any downstream activity during local accesses. Forwarded accesses run with a target that accepts and completes at once, and with one that delays both handshakes. The first shows the ready timing right after completion. The second shows that request fields are held and that only one request is in flight. Error completions on both a load and a store, extreme field values in the index register, and a final local read-back show that the error substitution, the field packing and the isolation of the scratch register are correct.

// File: rtl/cfgb_pkg.sv
// Package: shared types and field positions of the configuration index bridge.
// Assumes a 32-bit processor data bus and a 256-byte configuration space per function.
package cfgb_pkg;
    localparam int DW      = 32;
    localparam int BEW     = DW / 8;
    localparam int BUS_W   = 8;
    localparam int DEV_W   = 5;
    localparam int FN_W    = 3;
    localparam int REG_W   = 6;

    // Decoded contents of the index register (reserved bits are not stored)
    typedef struct packed {
        logic             en;
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
        logic [REG_W-1:0] regno;
    } cfg_index_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } seq_state_t;

    // Rebuild the architectural 32-bit index word; reserved bits read zero
    function automatic logic [DW-1:0] idx_to_word(input cfg_index_t i);
        return {i.en, 7'b0, i.bus, i.dev, i.fn, i.regno, 2'b00};
    endfunction
endpackage

// File: rtl/cfgb_regs.sv
// Module: holds the index register and the local scratch data register.
// Assumes write strobes are single-cycle and already decoded by the parent.
module cfgb_regs
    import cfgb_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_idx,
    input  logic           wr_loc,
    input  logic [DW-1:0]  wdata,
    input  logic [BEW-1:0] be,
    output cfg_index_t     idx,
    output logic [DW-1:0]  loc_data
);
    cfg_index_t idx_q;
    logic [DW-1:0] loc_q;

    // Index register: each field follows the byte lane that carries it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (wr_idx) begin
            if (be[3]) idx_q.en    <= wdata[31];
            if (be[2]) idx_q.bus   <= wdata[23:16];
            if (be[1]) begin
                idx_q.dev <= wdata[15:11];
                idx_q.fn  <= wdata[10:8];
            end
            if (be[0]) idx_q.regno <= wdata[7:2];
        end
    end

    // Local data register: one generated byte lane per byte enable
    for (genvar b = 0; b < BEW; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                loc_q[8*b +: 8] <= '0;
            else if (wr_loc && be[b])
                loc_q[8*b +: 8] <= wdata[8*b +: 8];
        end
    end

    assign idx      = idx_q;
    assign loc_data = loc_q;
endmodule

// File: rtl/cfgb_seq.sv
// Module: sequences one configuration transaction through request and completion.
// Assumes start is raised only while idle and the processor holds its access stable.
module cfgb_seq
    import cfgb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_we,
    input  logic [DW-1:0]    start_wdata,
    input  logic [BEW-1:0]   start_be,
    input  cfg_index_t       idx,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    rdata,
    output logic             req_valid,
    input  logic             req_ready,
    output logic             req_write,
    output logic [BUS_W-1:0] req_bus,
    output logic [DEV_W-1:0] req_dev,
    output logic [FN_W-1:0]  req_fn,
    output logic [REG_W-1:0] req_reg,
    output logic [DW-1:0]    req_wdata,
    output logic [BEW-1:0]   req_be,
    input  logic             cpl_valid,
    output logic             cpl_ready,
    input  logic             cpl_err,
    input  logic [DW-1:0]    cpl_data
);
    seq_state_t    st_q, st_d;
    cfg_index_t    tgt_q;
    logic          we_q;
    logic [DW-1:0] wd_q, rd_q;
    logic [BEW-1:0] be_q;

    // Next-state logic of the transaction sequencer
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start)     st_d = ST_REQ;
            ST_REQ:  if (req_ready) st_d = ST_WAIT;
            ST_WAIT: if (cpl_valid) st_d = ST_DONE;
            ST_DONE:                st_d = ST_IDLE;
            default:                st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Capture the request payload when a transaction starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
            we_q  <= 1'b0;
            wd_q  <= '0;
            be_q  <= '0;
        end else if (st_q == ST_IDLE && start) begin
            tgt_q <= idx;
            we_q  <= start_we;
            wd_q  <= start_wdata;
            be_q  <= start_be;
        end
    end

    // Capture completion data, substituting all-ones on error
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (st_q == ST_WAIT && cpl_valid)
            rd_q <= cpl_err ? '1 : cpl_data;
    end

    assign busy      = (st_q != ST_IDLE);
    assign done      = (st_q == ST_DONE);
    assign rdata     = rd_q;
    assign req_valid = (st_q == ST_REQ);
    assign cpl_ready = (st_q == ST_WAIT);
    assign req_write = we_q;
    assign req_bus   = tgt_q.bus;
    assign req_dev   = tgt_q.dev;
    assign req_fn    = tgt_q.fn;
    assign req_reg   = tgt_q.regno;
    assign req_wdata = wd_q;
    assign req_be    = be_q;
endmodule

// File: rtl/cfg_index_bridge.sv
// Module: top of the index/data configuration access bridge.
// Decodes processor accesses to the index and data registers and either serves
// them locally or forwards them as configuration requests. Assumes the processor
// holds its access stable until cpu_ready and issues one access at a time.
module cfg_index_bridge
    import cfgb_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int IDX_OFS  = 0,
    parameter int DATA_OFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    input  logic [3:0]        cpu_be,
    output logic              cpu_ready,
    output logic [31:0]       cpu_rdata,
    output logic              dn_req_valid,
    input  logic              dn_req_ready,
    output logic              dn_req_write,
    output logic [7:0]        dn_req_bus,
    output logic [4:0]        dn_req_dev,
    output logic [2:0]        dn_req_fn,
    output logic [5:0]        dn_req_reg,
    output logic [31:0]       dn_req_wdata,
    output logic [3:0]        dn_req_be,
    input  logic              dn_cpl_valid,
    output logic              dn_cpl_ready,
    input  logic              dn_cpl_err,
    input  logic [31:0]       dn_cpl_data
);
    localparam logic [ADDR_W-1:0] IDX_A  = ADDR_W'(IDX_OFS);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

    cfg_index_t idx;
    logic [DW-1:0] loc_data, seq_rdata;
    logic sel_idx, sel_dat, cfg_hit, seq_busy, seq_done;

    // Register select decode
    always_comb begin
        sel_idx = cpu_valid && (cpu_addr == IDX_A);
        sel_dat = cpu_valid && (cpu_addr == DATA_A);
        cfg_hit = sel_dat && idx.en;
    end

    cfgb_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_idx   (sel_idx && cpu_we),
        .wr_loc   (sel_dat && !idx.en && cpu_we),
        .wdata    (cpu_wdata),
        .be       (cpu_be),
        .idx      (idx),
        .loc_data (loc_data)
    );

    cfgb_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (cfg_hit && !seq_busy),
        .start_we    (cpu_we),
        .start_wdata (cpu_wdata),
        .start_be    (cpu_be),
        .idx         (idx),
        .busy        (seq_busy),
        .done        (seq_done),
        .rdata       (seq_rdata),
        .req_valid   (dn_req_valid),
        .req_ready   (dn_req_ready),
        .req_write   (dn_req_write),
        .req_bus     (dn_req_bus),
        .req_dev     (dn_req_dev),
        .req_fn      (dn_req_fn),
        .req_reg     (dn_req_reg),
        .req_wdata   (dn_req_wdata),
        .req_be      (dn_req_be),
        .cpl_valid   (dn_cpl_valid),
        .cpl_ready   (dn_cpl_ready),
        .cpl_err     (dn_cpl_err),
        .cpl_data    (dn_cpl_data)
    );

    // Processor handshake: local accesses finish at once, forwarded ones on done
    always_comb begin
        cpu_ready = cpu_valid && (cfg_hit ? seq_done : 1'b1);
        if (sel_idx)      cpu_rdata = idx_to_word(idx);
        else if (cfg_hit) cpu_rdata = seq_rdata;
        else if (sel_dat) cpu_rdata = loc_data;
        else              cpu_rdata = '0;
    end
endmodule

// File: rtl/cfgb_chk.sv
// Module: protocol checker for the configuration index bridge, bound to the top.
// Assumes it observes the top module's ports only.
module cfgb_chk #(
    parameter int ADDR_W  = 4,
    parameter int IDX_OFS = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_ready,
    input logic [31:0]       cpu_rdata,
    input logic              dn_req_valid,
    input logic              dn_req_ready,
    input logic              dn_req_write,
    input logic [7:0]        dn_req_bus,
    input logic [4:0]        dn_req_dev,
    input logic [2:0]        dn_req_fn,
    input logic [5:0]        dn_req_reg,
    input logic [31:0]       dn_req_wdata,
    input logic [3:0]        dn_req_be,
    input logic              dn_cpl_valid,
    input logic              dn_cpl_ready,
    input logic              dn_cpl_err
);
    logic pending;

    // Track a request accepted but not yet completed
    always_ff @(posedge clk) begin
        if (!rst_n)                           pending <= 1'b0;
        else if (dn_req_valid && dn_req_ready) pending <= 1'b1;
        else if (dn_cpl_valid && dn_cpl_ready) pending <= 1'b0;
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_req_write)
        && $stable(dn_req_bus) && $stable(dn_req_dev) && $stable(dn_req_fn)
        && $stable(dn_req_reg) && $stable(dn_req_wdata) && $stable(dn_req_be));

    // R9
    single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !dn_req_valid);

    // R6
    stall_until_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !cpu_ready);

    // R6
    ready_after_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_cpl_valid && dn_cpl_ready |=> cpu_ready);

    // R8
    err_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_cpl_valid && dn_cpl_ready && dn_cpl_err && !cpu_we |=> cpu_rdata == 32'hFFFF_FFFF);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid && cpu_ready && !cpu_we && cpu_addr == ADDR_W'(IDX_OFS)
        |-> cpu_rdata[30:24] == 7'd0 && cpu_rdata[1:0] == 2'd0);
endmodule

bind cfg_index_bridge cfgb_chk #(.ADDR_W(ADDR_W), .IDX_OFS(IDX_OFS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_valid    (cpu_valid),
    .cpu_we       (cpu_we),
    .cpu_addr     (cpu_addr),
    .cpu_ready    (cpu_ready),
    .cpu_rdata    (cpu_rdata),
    .dn_req_valid (dn_req_valid),
    .dn_req_ready (dn_req_ready),
    .dn_req_write (dn_req_write),
    .dn_req_bus   (dn_req_bus),
    .dn_req_dev   (dn_req_dev),
    .dn_req_fn    (dn_req_fn),
    .dn_req_reg   (dn_req_reg),
    .dn_req_wdata (dn_req_wdata),
    .dn_req_be    (dn_req_be),
    .dn_cpl_valid (dn_cpl_valid),
    .dn_cpl_ready (dn_cpl_ready),
    .dn_cpl_err   (dn_cpl_err)
);

// File: tb/test_cfg_index_bridge.sv
`timescale 1ns/1ps
// Bench: behavioural model of the index/data registers and a delay-programmable
// downstream target; outputs are sampled 1 ns after the falling edge.
module test_cfg_index_bridge;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [3:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0] cpu_be = '0;
    logic cpu_ready;
    logic [31:0] cpu_rdata;
    logic dn_req_valid, dn_req_ready = 1'b0, dn_req_write;
    logic [7:0] dn_req_bus;
    logic [4:0] dn_req_dev;
    logic [2:0] dn_req_fn;
    logic [5:0] dn_req_reg;
    logic [31:0] dn_req_wdata;
    logic [3:0] dn_req_be;
    logic dn_cpl_valid = 1'b0, dn_cpl_ready, dn_cpl_err = 1'b0;
    logic [31:0] dn_cpl_data = '0;

    int checks = 0, errors = 0;
    // model state
    logic [31:0] m_idx = '0, m_loc = '0;
    bit m_cfg = 0;
    // target behaviour and record
    int rsp_rdy_dly = 0, rsp_cpl_dly = 0;
    bit rsp_err = 0;
    logic [31:0] rsp_data = '0;
    int req_count = 0;
    bit cpl_seen = 0;
    realtime cpl_t = 0;
    logic r_write;
    logic [7:0] r_bus;
    logic [4:0] r_dev;
    logic [2:0] r_fn;
    logic [5:0] r_reg;
    logic [31:0] r_wdata;
    logic [3:0] r_be;

    always #2.5 clk = ~clk;

    cfg_index_bridge i_cfg_index_bridge (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    // One processor access; returns read data and wait cycles
    task automatic cpu_acc(input bit we, input logic [3:0] a, input logic [31:0] wd,
                           input logic [3:0] be, output logic [31:0] rd, output int waits);
        bit cfg;
        @(negedge clk);
        cfg = (a == 4'h4) && m_idx[31];
        m_cfg = cfg;
        cpl_seen = 0;
        cpu_valid = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
        waits = 0;
        #1;
        while (!cpu_ready) begin
            @(negedge clk); #1; waits++;
        end
        rd = cpu_rdata;
        if (cfg) chk(cpl_seen && ($realtime - cpl_t) < 5.0, "R6 ready right after completion",
                     32'(waits), 32'(cpl_seen));
        // update model
        if (we && a == 4'h0) m_idx = merge(m_idx, wd, be) & 32'h80FF_FFFC;
        if (we && a == 4'h4 && !cfg) m_loc = merge(m_loc, wd, be);
        @(posedge clk);
        @(negedge clk);
        cpu_valid = 0;
        m_cfg = 0;
    endtask

    // Downstream target with programmable handshake delays
    initial begin
        forever begin
            @(negedge clk); #0.5;
            if (dn_req_valid) begin
                {r_write, r_bus, r_dev, r_fn, r_reg, r_wdata, r_be} =
                    {dn_req_write, dn_req_bus, dn_req_dev, dn_req_fn, dn_req_reg, dn_req_wdata, dn_req_be};
                for (int i = 0; i < rsp_rdy_dly; i++) begin
                    @(negedge clk); #0.5;
                    chk(dn_req_valid && {dn_req_write, dn_req_bus, dn_req_dev, dn_req_fn, dn_req_reg, dn_req_wdata, dn_req_be}
                        == {r_write, r_bus, r_dev, r_fn, r_reg, r_wdata, r_be}, "R7 request held",
                        dn_req_wdata, r_wdata);
                end
                dn_req_ready = 1;
                @(posedge clk);
                req_count++;
                @(negedge clk);
                dn_req_ready = 0;
                for (int i = 0; i < rsp_cpl_dly; i++) @(negedge clk);
                dn_cpl_valid = 1; dn_cpl_err = rsp_err; dn_cpl_data = rsp_data;
                #0.5;
                while (!dn_cpl_ready) begin @(negedge clk); #0.5; end
                @(posedge clk);
                cpl_seen = 1; cpl_t = $realtime;
                @(negedge clk);
                dn_cpl_valid = 0; dn_cpl_err = 0;
            end
        end
    end

    // Per-cycle comparison: no downstream activity outside a forwarded access
    initial begin
        forever begin
            @(negedge clk); #1;
            if (rst_n && !m_cfg && !cpu_valid)
                chk(!dn_req_valid && !dn_cpl_ready, "R3 idle downstream",
                    {30'd0, dn_req_valid, dn_cpl_ready}, 32'd0);
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // Forwarded access with target setup and request field checks
    task automatic cfg_acc(input bit we, input logic [31:0] wd, input logic [3:0] be,
                           input int rd_dly, input int cp_dly, input bit err, input logic [31:0] cd,
                           output logic [31:0] rd);
        int w, n0;
        rsp_rdy_dly = rd_dly; rsp_cpl_dly = cp_dly; rsp_err = err; rsp_data = cd;
        n0 = req_count;
        cpu_acc(we, 4'h4, wd, be, rd, w);
        chk(req_count == n0 + 1, "R9 one request per access", 32'(req_count - n0), 32'd1);
        chk(r_write == we && r_bus == m_idx[23:16] && r_dev == m_idx[15:11] &&
            r_fn == m_idx[10:8] && r_reg == m_idx[7:2],
            we ? "R4 write request fields" : "R5 read request fields",
            {r_write, 7'd0, r_bus, r_dev, r_fn, r_reg, 2'b0}, {we, 7'd0, m_idx[23:2], 2'b0});
        if (we) chk(r_wdata == wd && r_be == be, "R4 write payload", r_wdata, wd);
    endtask

    initial begin
        logic [31:0] rd;
        int w;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        #1;
        chk(!dn_req_valid && !dn_cpl_ready && !cpu_ready, "R1 reset outputs",
            {29'd0, dn_req_valid, dn_cpl_ready, cpu_ready}, 32'd0);
        cpu_acc(0, 4'h0, 0, 0, rd, w); chk(rd == 0, "R1 index reset", rd, 0);
        cpu_acc(0, 4'h4, 0, 0, rd, w); chk(rd == 0, "R1 data reset", rd, 0);
        // R2 fields, reserved bits dropped, enable clear
        cpu_acc(1, 4'h0, 32'h7F5A_9AFF, 4'hF, rd, w);
        cpu_acc(0, 4'h0, 0, 0, rd, w); chk(rd == m_idx, "R2 index readback", rd, m_idx);
        cpu_acc(1, 4'h0, 32'hFFFF_FFFF, 4'b0100, rd, w);
        cpu_acc(0, 4'h0, 0, 0, rd, w); chk(rd == m_idx, "R2 byte lane gating", rd, m_idx);
        // R3 local data
        cpu_acc(1, 4'h4, 32'hA5A5_1234, 4'hF, rd, w); chk(w == 0, "R3 zero-wait store", 32'(w), 0);
        cpu_acc(1, 4'h4, 32'h0BAD_F00D, 4'b1010, rd, w);
        cpu_acc(0, 4'h4, 0, 0, rd, w); chk(rd == m_loc && w == 0, "R3 local byte-enable readback", rd, m_loc);
        // R11 unused offset
        cpu_acc(0, 4'h8, 0, 0, rd, w); chk(rd == 0 && w == 0, "R11 unused offset", rd, 0);
        // enable forwarding, target 0x5A/0x13/5/0x2F
        cpu_acc(1, 4'h0, 32'h805A_9DBC, 4'hF, rd, w);
        cfg_acc(1, 32'hCAFE_BABE, 4'hF, 2, 3, 0, 0, rd);
        cfg_acc(0, 0, 4'hF, 1, 2, 0, 32'h1234_5678, rd);
        chk(rd == 32'h1234_5678, "R5 completion data", rd, 32'h1234_5678);
        cfg_acc(0, 0, 4'hF, 0, 0, 1, 32'h0000_0055, rd);
        chk(rd == 32'hFFFF_FFFF, "R8 error load", rd, 32'hFFFF_FFFF);
        cfg_acc(1, 32'h1111_2222, 4'b0011, 3, 1, 1, 0, rd);
        chk(1'b1, "R8 error store finished", 0, 0);
        // extreme fields with immediate target
        cpu_acc(1, 4'h0, 32'hFFFF_FFFF, 4'hF, rd, w);
        cfg_acc(1, 32'h0000_0001, 4'b1000, 0, 0, 0, 0, rd);
        cfg_acc(0, 0, 4'hF, 0, 0, 0, 32'h8000_0001, rd);
        chk(rd == 32'h8000_0001, "R5 immediate completion", rd, 32'h8000_0001);
        // R10 local register untouched
        cpu_acc(1, 4'h0, 32'h0000_0000, 4'b1000, rd, w);
        cpu_acc(0, 4'h4, 0, 0, rd, w); chk(rd == m_loc, "R10 local data preserved", rd, m_loc);
        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule